// File: doc/BRIEF.md
# Buck converter PWM/PFM mode controller

This block holds the digital mode-selection logic of a two-output step-down regulator. It decides whether the converter runs in pulse-width (PWM) or pulse-frequency (PFM) operation. It also issues a one-cycle start pulse at the beginning of every switching cycle and drives a status bit that tells the rest of the system which mode is active. The analog loop, the power stage and current sensing sit outside it.

The combined mode/sync input can be at one of three states: held low, held high, or carrying a clock. The block measures the spacing of rising edges on that pin in system-clock counts. When the spacing is inside a programmed window, it treats the pin as an external clock. It then forces PWM and starts each switching cycle on that clock's rising edge. Otherwise the cycles are paced by an internal reference divider, and the pin only counts as a level once it has been quiet for a timeout.

In automatic mode with the pin low, a light-load comparator flag is sampled once per switching cycle. A run of consecutive asserted samples moves the converter into PFM. The first deasserted sample brings it straight back to PWM. Enable, auto select and the light-load flag are taken as signals that are already synchronous to the system clock. Only the mode/sync pin passes through a synchronizer.

Top module: `buck_mode_ctrl`

## Requirements
- R1: While `en_i` is low, `cyc_start_o` stays 0 and `pfm_stat_o` stays 0 (shutdown), whatever the other inputs do.
- R2: With `en_i` high, `auto_i` low and no valid clock on the pin, a static low level selects PFM and a static high level selects PWM.
- R3: While a valid clock is present on `mode_sync_i`, the mode is PWM for either value of `auto_i` and of `light_load_i`.
- R4: A pin clock is valid when its rising-edge spacing P, in system clocks, satisfies MIN_PER <= P <= MAX_PER. The defaults are 32 and 80 at 48 MHz, which is 1.5 MHz to 600 kHz. While the clock is valid, every rising edge gives exactly one `cyc_start_o` pulse, and that pulse appears 3 system clocks after the pin edge (2 synchronizer stages plus 1 output register).
- R5: With auto high and a static low pin, PFM is entered at the switching cycle in which `light_load_i` has been seen high at RUN_LEN (default 16) consecutive cycle starts. After RUN_LEN-1 such samples the mode is still PWM.
- R6: With auto high and a static high pin, the mode is PWM regardless of `light_load_i`.
- R7: When there is no valid pin clock, `cyc_start_o` pulses once every OSC_DIV system clocks.
- R8: `pfm_stat_o` is 1 in PFM and 0 in PWM.
- R9: In automatic mode, a cycle start that samples `light_load_i` low returns the block to PWM at that cycle and restarts the run count from zero. Asserted samples taken before the drop do not count toward a later entry.
- R10: The pin is taken as a static level only after 2*MAX_PER system clocks with no change on it. A pin that toggles outside the valid window leaves the last static level in force and keeps the internal pacing.
- R11: On leaving shutdown the block starts in PWM, and a full run of RUN_LEN light-load samples is needed again before it enters PFM.
- R12: During synchronous reset (`rst` high), `cyc_start_o` and `pfm_stat_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable; low means shutdown |
| auto_i | input | 1 | 1 = automatic PWM/PFM choice, 0 = forced by pin |
| mode_sync_i | input | 1 | Mode level or external sync clock (asynchronous) |
| light_load_i | input | 1 | Comparator flag: total load current is low |
| cyc_start_o | output | 1 | One-cycle pulse at each switching-cycle start |
| pfm_stat_o | output | 1 | Mode status: 1 = PFM, 0 = PWM |

## Verification
The bench builds the block with MIN_PER=8, MAX_PER=20, OSC_DIV=10 and RUN_LEN=16, which makes the quiet timeout 40 clocks. With these values, pin clocks at the two window edges (periods 8 and 20) and just outside them (6 and 30) take only a few dozen cycles each. The 16-sample PFM entry, the restart of the run after a drop and the restart after shutdown all fit in a few hundred clocks. Pulse counts over a 240-clock window divide evenly by every tested period, so each pacing source gives an exact expected count.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  typedef enum logic {
    MODE_PWM = 1'b0,
    MODE_PFM = 1'b1
  } conv_mode_e;

  typedef enum logic [1:0] {
    POL_OFF,
    POL_PWM,
    POL_PFM,
    POL_AUTO
  } mode_policy_e;

  // What the pin monitor reports about the mode/sync input
  typedef struct packed {
    logic sync_ok;   // a clock inside the frequency window is present
    logic lvl;       // last settled static level
    logic edge_up;   // rising edge seen this cycle (synchronized)
  } pin_view_t;

  function automatic mode_policy_e pick_policy(input logic en,
                                               input logic auto_sel,
                                               input logic sync_ok,
                                               input logic lvl);
    if (!en)              return POL_OFF;
    if (sync_ok || lvl)   return POL_PWM;
    if (!auto_sel)        return POL_PFM;
    return POL_AUTO;
  endfunction

endpackage

// File: rtl/bmc_sync.sv
module bmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stg;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= 1'b0;
        else     stg[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= 1'b0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/bmc_pin_monitor.sv
module bmc_pin_monitor
  import bmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PER     = 32,
  parameter int MAX_PER     = 80
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en_i,
  input  logic      pin_i,
  output pin_view_t view_o
);

  localparam int QUIET_LIM = 2 * MAX_PER;
  localparam int CW        = $clog2(QUIET_LIM + 1);
  localparam logic [CW-1:0] LIM_C = CW'(QUIET_LIM);
  localparam logic [CW-1:0] LO_C  = CW'(MIN_PER - 1);
  localparam logic [CW-1:0] HI_C  = CW'(MAX_PER - 1);

  logic          pin_s;
  logic          prev_q;
  logic          valid_q;
  logic          lvl_q;
  logic [CW-1:0] per_cnt;
  logic [CW-1:0] quiet_cnt;
  logic          rise;
  logic          in_win;

  bmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_i),
    .q_o (pin_s)
  );

  assign rise   = pin_s & ~prev_q;
  // per_cnt holds (spacing - 1) when the closing edge arrives
  assign in_win = (per_cnt >= LO_C) && (per_cnt <= HI_C);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q    <= 1'b0;
      valid_q   <= 1'b0;
      lvl_q     <= 1'b0;
      per_cnt   <= LIM_C;
      quiet_cnt <= '0;
    end else if (!en_i) begin
      prev_q    <= pin_s;
      valid_q   <= 1'b0;
      lvl_q     <= pin_s;
      per_cnt   <= LIM_C;
      quiet_cnt <= '0;
    end else begin
      prev_q <= pin_s;
      // edge-to-edge period measurement
      if (rise) begin
        per_cnt <= '0;
        valid_q <= in_win;
      end else if (per_cnt != LIM_C) begin
        per_cnt <= per_cnt + 1'b1;
      end else begin
        valid_q <= 1'b0;
      end
      // static level only after a long quiet stretch
      if (pin_s != prev_q) begin
        quiet_cnt <= '0;
      end else if (quiet_cnt != LIM_C) begin
        quiet_cnt <= quiet_cnt + 1'b1;
      end else begin
        lvl_q <= pin_s;
      end
    end
  end

  assign view_o.sync_ok = valid_q;
  assign view_o.lvl     = lvl_q;
  assign view_o.edge_up = rise;

  // R4: lock is only gained from an edge spacing inside the window
  p_lock_in_window_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> ($past(per_cnt) >= LO_C && $past(per_cnt) <= HI_C));

  // R10: a silent pin cannot remain a valid clock
  p_silence_drops_lock_r10: assert property (@(posedge clk) disable iff (rst)
    (en_i && !rise && per_cnt == LIM_C) |=> !valid_q);

endmodule

// File: rtl/bmc_ref_osc.sv
module bmc_ref_osc #(
  parameter int DIV = 53
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en_i)        cnt_q <= '0;
    else if (cnt_q == LAST_C) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST_C);

endmodule

// File: rtl/bmc_mode_ctrl.sv
module bmc_mode_ctrl
  import bmc_pkg::*;
#(
  parameter int RUN_LEN = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       auto_i,
  input  logic       light_i,
  input  logic       strobe_i,
  input  pin_view_t  view_i,
  output conv_mode_e mode_o
);

  localparam int RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_C = RW'(RUN_LEN);

  mode_policy_e policy;
  conv_mode_e   mode_q;
  logic [RW-1:0] run_q;
  logic [RW-1:0] run_next;

  assign policy = pick_policy(en_i, auto_i, view_i.sync_ok, view_i.lvl);

  always_comb begin
    run_next = run_q;
    if (strobe_i) begin
      if (!light_i)            run_next = '0;
      else if (run_q != RUN_C) run_next = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      mode_q <= MODE_PWM;
    end else begin
      case (policy)
        POL_OFF, POL_PWM: begin
          run_q  <= '0;
          mode_q <= MODE_PWM;
        end
        POL_PFM: begin
          run_q  <= '0;
          mode_q <= MODE_PFM;
        end
        default: begin
          run_q  <= run_next;
          mode_q <= (run_next == RUN_C) ? MODE_PFM : MODE_PWM;
        end
      endcase
    end
  end

  assign mode_o = mode_q;

  // R2: forced low level gives PFM
  p_forced_pfm_r2: assert property (@(posedge clk) disable iff (rst)
    (en_i && !auto_i && !view_i.sync_ok && !view_i.lvl) |=> (mode_q == MODE_PFM));

  // R3: a valid pin clock forces PWM
  p_sync_forces_pwm_r3: assert property (@(posedge clk) disable iff (rst)
    (en_i && view_i.sync_ok) |=> (mode_q == MODE_PWM));

  // R6: static high level keeps PWM
  p_high_keeps_pwm_r6: assert property (@(posedge clk) disable iff (rst)
    (en_i && view_i.lvl) |=> (mode_q == MODE_PWM));

  // R5: automatic PFM entry happens only at a cycle start
  p_entry_at_strobe_r5: assert property (@(posedge clk) disable iff (rst)
    (policy == POL_AUTO && mode_q == MODE_PWM && !strobe_i) |=> (mode_q == MODE_PWM));

  // R9: a deasserted sample exits PFM and restarts the run
  p_drop_exits_r9: assert property (@(posedge clk) disable iff (rst)
    (policy == POL_AUTO && strobe_i && !light_i) |=> (mode_q == MODE_PWM && run_q == '0));

endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
  import bmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PER     = 32,
  parameter int MAX_PER     = 80,
  parameter int OSC_DIV     = 53,
  parameter int RUN_LEN     = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic auto_i,
  input  logic mode_sync_i,
  input  logic light_load_i,
  output logic cyc_start_o,
  output logic pfm_stat_o
);

  pin_view_t  view;
  logic       osc_tick;
  logic       strobe;
  conv_mode_e mode;

  bmc_pin_monitor #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_PER     (MIN_PER),
    .MAX_PER     (MAX_PER)
  ) u_pin (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .pin_i  (mode_sync_i),
    .view_o (view)
  );

  bmc_ref_osc #(.DIV(OSC_DIV)) u_osc (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .tick_o (osc_tick)
  );

  // cycle start: external edge while locked, internal tick otherwise
  assign strobe = en_i && (view.sync_ok ? view.edge_up : osc_tick);

  bmc_mode_ctrl #(.RUN_LEN(RUN_LEN)) u_mode (
    .clk      (clk),
    .rst      (rst),
    .en_i     (en_i),
    .auto_i   (auto_i),
    .light_i  (light_load_i),
    .strobe_i (strobe),
    .view_i   (view),
    .mode_o   (mode)
  );

  always_ff @(posedge clk) begin
    if (rst) cyc_start_o <= 1'b0;
    else     cyc_start_o <= strobe;
  end

  assign pfm_stat_o = (mode == MODE_PFM);

  // R1: shutdown silences the start pulse and reports PWM
  p_off_is_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!cyc_start_o && !pfm_stat_o));

  // R4: each locked rising edge yields a start pulse
  p_edge_gives_start_r4: assert property (@(posedge clk) disable iff (rst)
    (en_i && view.sync_ok && view.edge_up) |=> cyc_start_o);

  // R7: the internal tick is ignored while locked to the pin clock
  p_tick_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (view.sync_ok && !view.edge_up) |=> !cyc_start_o);

endmodule

// File: tb/buck_mode_ctrl_test.sv
module buck_mode_ctrl_test;

  localparam int MIN_P = 8;
  localparam int MAX_P = 20;
  localparam int ODIV  = 10;
  localparam int RUN   = 16;
  localparam int WIN   = 240;
  localparam int SETTLE = 400;
  localparam int NROW  = 14;

  // columns: en, auto, pin kind (0 low,1 high,2 clock), period, light,
  //          expected pfm, expected pulses in WIN, requirement number
  localparam int TV [NROW][8] = '{
    '{1, 0, 0,  0, 0, 1, 24,  2},  // R2 forced low -> PFM, R7 pacing
    '{1, 0, 1,  0, 0, 0, 24,  2},  // R2 forced high -> PWM
    '{1, 0, 2, 12, 0, 0, 20,  3},  // R3 clock forces PWM
    '{1, 1, 2, 12, 1, 0, 20,  3},  // R3 clock beats light load in auto
    '{1, 1, 1,  0, 1, 0, 24,  6},  // R6 auto, high pin
    '{1, 1, 0,  0, 1, 1, 24,  5},  // R5 auto, low pin, light load
    '{1, 1, 0,  0, 0, 0, 24,  9},  // R9 flag drops
    '{1, 0, 0,  0, 0, 1, 24,  2},  // R2 forced PFM again
    '{1, 0, 2,  6, 0, 1, 24, 10},  // R10 too fast: level held, internal pacing
    '{1, 0, 2, 30, 0, 1, 24, 10},  // R10 too slow: level held
    '{1, 0, 2,  8, 0, 0, 30,  4},  // R4 window lower edge
    '{1, 0, 2, 20, 0, 0, 12,  4},  // R4 window upper edge
    '{0, 0, 0,  0, 0, 0,  0,  1},  // R1 shutdown
    '{0, 1, 2, 12, 1, 0,  0,  1}   // R1 shutdown with clock
  };

  logic clk = 1'b0;
  logic rst;
  logic en;
  logic auto_s;
  logic ms_drv;
  logic ll;
  logic cyc_start;
  logic pfm;

  int ms_kind;
  int ms_per;
  int ph;
  int checks;
  int errs;

  always #2.5 clk = ~clk;

  buck_mode_ctrl #(
    .SYNC_STAGES (2),
    .MIN_PER     (MIN_P),
    .MAX_PER     (MAX_P),
    .OSC_DIV     (ODIV),
    .RUN_LEN     (RUN)
  ) uut (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en),
    .auto_i       (auto_s),
    .mode_sync_i  (ms_drv),
    .light_load_i (ll),
    .cyc_start_o  (cyc_start),
    .pfm_stat_o   (pfm)
  );

  // mode/sync pin generator, driven on falling edges
  initial begin
    ms_drv = 1'b0;
    ph = 0;
    forever begin
      @(negedge clk);
      if (ms_kind == 2) begin
        ph = (ph + 1 >= ms_per) ? 0 : ph + 1;
        ms_drv = (ph < ms_per / 2);
      end else begin
        ms_drv = (ms_kind == 1);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_pulse();
    int guard = 0;
    do begin
      @(posedge clk);
      #1;
      guard++;
    end while (!cyc_start && guard < 1000);
  endtask

  initial begin
    checks = 0;
    errs = 0;
    rst = 1'b1;
    en = 1'b1;
    auto_s = 1'b0;
    ll = 1'b0;
    ms_kind = 0;
    ms_per = 12;

    // R12: reset state
    step(3);
    chk("R12 start pulse during reset", int'(cyc_start), 0);
    chk("R12 status during reset", int'(pfm), 0);
    rst = 1'b0;

    // table walk
    for (int i = 0; i < NROW; i++) begin
      int cnt;
      en      = (TV[i][0] != 0);
      auto_s  = (TV[i][1] != 0);
      ms_kind = TV[i][2];
      ms_per  = (TV[i][3] > 0) ? TV[i][3] : 12;
      ll      = (TV[i][4] != 0);
      step(SETTLE);
      cnt = 0;
      for (int k = 0; k < WIN; k++) begin
        step(1);
        if (cyc_start) cnt++;
      end
      chk($sformatf("R%0d row %0d status (R8)", TV[i][7], i), int'(pfm), TV[i][5]);
      chk($sformatf("R%0d row %0d pulses (R7/R4 pacing)", TV[i][7], i), cnt, TV[i][6]);
    end

    // R4: pulse follows pin rising edge by 3 clocks
    en = 1'b1; auto_s = 1'b0; ll = 1'b0; ms_kind = 2; ms_per = 12;
    step(SETTLE);
    begin
      int n = 0;
      @(posedge ms_drv);
      do begin
        @(posedge clk);
        #1;
        n++;
      end while (!cyc_start && n < 20);
      chk("R4 start latency after pin edge", n, 3);
    end

    // R5 / R9: exact run length in auto mode
    auto_s = 1'b1; ms_kind = 0; ll = 1'b0;
    step(SETTLE);
    chk("R9 auto idle PWM", int'(pfm), 0);
    wait_pulse();
    ll = 1'b1;
    repeat (RUN - 1) wait_pulse();
    chk("R5 still PWM after 15 samples", int'(pfm), 0);
    wait_pulse();
    chk("R5 PFM after 16 samples (R8 status high)", int'(pfm), 1);
    ll = 1'b0;
    step(3);
    chk("R9 PFM held until next cycle start", int'(pfm), 1);
    wait_pulse();
    chk("R9 PWM at first low sample", int'(pfm), 0);

    // R9: interrupted run does not accumulate
    ll = 1'b1;
    repeat (10) wait_pulse();
    ll = 1'b0;
    wait_pulse();
    ll = 1'b1;
    repeat (RUN - 1) wait_pulse();
    chk("R9 run restarted after drop", int'(pfm), 0);
    wait_pulse();
    chk("R9 PFM after fresh 16-run", int'(pfm), 1);

    // R11: leaving shutdown restarts in PWM with cleared run
    en = 1'b0;
    step(5);
    chk("R1 shutdown status low", int'(pfm), 0);
    chk("R1 shutdown no pulse", int'(cyc_start), 0);
    en = 1'b1;
    step(2);
    chk("R11 PWM right after enable", int'(pfm), 0);
    repeat (RUN - 1) wait_pulse();
    chk("R11 still PWM after 15 samples", int'(pfm), 0);
    wait_pulse();
    chk("R11 PFM after full run", int'(pfm), 1);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule